// File: doc/BRIEF.md
# Watchdog Register Unlock Gate

This block sits in front of a watchdog's configuration registers and keeps them write-protected. The control word and the timeout word accept bus writes only while a short reconfiguration window is open. The window opens only when the right key is written to the counter address. The counting, refresh and reset-generation parts of the watchdog are outside this block. They take the stored control and timeout values from its outputs.

The control word holds three bits that the gate itself uses. Bit 13 selects the command width. When it is 1, only a single 32-bit key is accepted. When it is 0, only a two-step 16-bit key is accepted. This bit can be set once after reset. Bit 5 is the update permission: when it is 0, no key is accepted. Bit 7 is the watchdog enable. A write to the control word always ends the window, so any further change needs a fresh unlock.

Writes use a size code on `bus_size`: 0 is a byte, 1 is a halfword, 2 is a full word, and 3 is invalid. A key of the wrong width or the wrong value has no effect, and no error is signalled.

Top module: `wdog_unlock_gate`

## Requirements
- R1: After reset the control word is 0x000020A0 (bit 13 = 1, bit 7 = 1, bit 5 = 1), the timeout word is 0x0000FFFF, and `win_open` is 0.
- R2: While `win_open` is 0, writes to offset 0x0 (control) or offset 0x8 (timeout) leave both words unchanged.
- R3: With control bit 13 = 1, a size-2 write of 0xD928C520 to offset 0x4 sets `win_open` from the next cycle. A write to 0x4 with a different value or a different size does not.
- R4: With control bit 13 = 0, `win_open` is set only by size-1 writes to 0x4 of 0xC520 and then 0xD928 in the low halfword, on consecutive counter writes. Any other write to 0x4 in between restarts the sequence. A size-2 key is ignored.
- R5: After a key is accepted at clock edge E, protected writes are accepted at edges E+1 through E+255, and `win_open` is 0 after edge E+255.
- R6: An accepted control write closes the window from the next cycle. An accepted timeout write leaves it open.
- R7: Control bit 13 takes the written value only at the first accepted control write after reset. Later control writes leave it unchanged.
- R8: While control bit 5 is 0, no key opens the window.
- R9: `wdog_enabled` follows control bit 7, so clearing bit 7 during a window turns it off.
- R10: Protected registers accept only size-2 writes. Narrower writes in an open window change nothing.
- R11: A key accepted while the window is already open restarts the full 255-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 counter/key, 0x8 timeout |
| bus_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| ctrl_q | output | 32 | Stored control word |
| tmo_q | output | 32 | Stored timeout word |
| win_open | output | 1 | Reconfiguration window is open |
| wdog_enabled | output | 1 | Watchdog enable (control bit 7) |
| wide_cmd | output | 1 | Command width select (control bit 13) |
| ctrl_we | output | 1 | Control write accepted this cycle |
| tmo_we | output | 1 | Timeout write accepted this cycle |

## Verification
Every result of a write appears one clock edge after the edge that samples it. This covers the stored words, `win_open` after a key, and the window closing after a control write. The bench drives each write on a falling edge and reads the outputs at the next falling edge, half a cycle after the update. Window-length checks count idle cycles from the key edge so that the probe write lands exactly on edge E+255, and then on E+256. The two-step 16-bit key is checked with each kind of write between its halves.

// File: rtl/wdog_unlock_gate.sv
module wdog_unlock_gate #(
  parameter int          ADDR_W     = 4,
  parameter int          WIN_CYCLES = 255,
  parameter logic [31:0] CTRL_RST   = 32'h0000_20A0,
  parameter logic [31:0] TMO_RST    = 32'h0000_FFFF,
  parameter logic [31:0] KEY_WIDE   = 32'hD928_C520,
  parameter logic [15:0] KEY_FIRST  = 16'hC520,
  parameter logic [15:0] KEY_SECOND = 16'hD928
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       tmo_q,
  output logic              win_open,
  output logic              wdog_enabled,
  output logic              wide_cmd,
  output logic              ctrl_we,
  output logic              tmo_we
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_KEY  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_TMO  = ADDR_W'(8);
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam int BIT_WIDE = 13;
  localparam int BIT_EN   = 7;
  localparam int BIT_UPD  = 5;

  logic [CNT_W-1:0] win_cnt;
  logic             half_armed;
  logic             wide_fixed;

  wire hit_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  wire hit_key  = bus_wr && (bus_addr == OFF_KEY);
  wire hit_tmo  = bus_wr && (bus_addr == OFF_TMO);
  wire upd_ok   = ctrl_q[BIT_UPD];

  wire wide_key  = hit_key && wide_cmd && bus_size == SZ_WORD && bus_wdata == KEY_WIDE;
  wire half_lo   = hit_key && !wide_cmd && bus_size == SZ_HALF && bus_wdata[15:0] == KEY_FIRST;
  wire half_hi   = hit_key && !wide_cmd && bus_size == SZ_HALF && bus_wdata[15:0] == KEY_SECOND
                   && half_armed;
  wire key_ok    = upd_ok && (wide_key || half_hi);

  assign win_open     = win_cnt != '0;
  assign wide_cmd     = ctrl_q[BIT_WIDE];
  assign wdog_enabled = ctrl_q[BIT_EN];
  assign ctrl_we      = hit_ctrl && bus_size == SZ_WORD && win_open;
  assign tmo_we       = hit_tmo  && bus_size == SZ_WORD && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_armed <= 1'b0;
    else if (hit_key) half_armed <= half_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_cnt <= '0;
    else if (key_ok)   win_cnt <= CNT_W'(WIN_CYCLES);
    else if (ctrl_we)  win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      wide_fixed <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_q           <= bus_wdata;
      ctrl_q[BIT_WIDE] <= wide_fixed ? ctrl_q[BIT_WIDE] : bus_wdata[BIT_WIDE];
      wide_fixed       <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= TMO_RST;
    else if (tmo_we) tmo_q <= bus_wdata;
  end

  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(ctrl_q));
  assert_locked_tmo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(tmo_q));
  assert_window_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> win_cnt == CNT_W'(WIN_CYCLES));
  assert_ctrl_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !win_open);
  assert_wide_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wide_fixed |=> $stable(ctrl_q[BIT_WIDE]));
  assert_no_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[BIT_UPD] && !win_open) |=> !win_open);
  assert_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != SZ_WORD && !key_ok) |=> $stable(ctrl_q) && $stable(tmo_q));
endmodule

// File: tb/wdog_unlock_gate_test.sv
module wdog_unlock_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] ctrl_q, tmo_q;
  logic        win_open, wdog_enabled, wide_cmd, ctrl_we, tmo_we;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdog_unlock_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .tmo_q(tmo_q),
    .win_open(win_open), .wdog_enabled(wdog_enabled), .wide_cmd(wide_cmd),
    .ctrl_we(ctrl_we), .tmo_we(tmo_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset_R1();
    do_reset();
    check("R1 ctrl", ctrl_q, 32'h0000_20A0);
    check("R1 tmo", tmo_q, 32'h0000_FFFF);
    check("R1 win", win_open, 0);
  endtask

  task automatic t_locked_R2();
    do_reset();
    wr(4'h0, 2'd2, 32'h0);
    wr(4'h8, 2'd2, 32'h1234);
    check("R2 ctrl", ctrl_q, 32'h0000_20A0);
    check("R2 tmo", tmo_q, 32'h0000_FFFF);
    check("R2 win", win_open, 0);
  endtask

  task automatic t_wide_key_R3();
    do_reset();
    wr(4'h4, 2'd2, 32'hD928_C521);
    check("R3 bad value", win_open, 0);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd1, 32'h0000_D928);
    check("R3 narrow key", win_open, 0);
    wr(4'h4, 2'd2, 32'hD928_C520);
    check("R3 good key", win_open, 1);
    wr(4'h8, 2'd1, 32'h0000_0077);
    check("R10 narrow tmo", tmo_q, 32'h0000_FFFF);
    wr(4'h0, 2'd0, 32'h0);
    check("R10 narrow ctrl", ctrl_q, 32'h0000_20A0);
    wr(4'h8, 2'd2, 32'h0000_0055);
    check("R6 tmo write", tmo_q, 32'h0000_0055);
    check("R6 tmo keeps open", win_open, 1);
    wr(4'h0, 2'd2, 32'h0000_2020);
    check("R9 ctrl", ctrl_q, 32'h0000_2020);
    check("R9 enable off", wdog_enabled, 0);
    check("R6 ctrl closes", win_open, 0);
    wr(4'h0, 2'd2, 32'h0000_20A0);
    check("R2 relocked", ctrl_q, 32'h0000_2020);
  endtask

  task automatic t_window_R5();
    do_reset();
    wr(4'h4, 2'd2, 32'hD928_C520);
    idle(253);
    check("R5 open at E+254", win_open, 1);
    idle(1);
    wr(4'h8, 2'd2, 32'h0000_0100);
    check("R5 write at E+255", tmo_q, 32'h0000_0100);
    check("R5 closed", win_open, 0);
    wr(4'h8, 2'd2, 32'h0000_0200);
    check("R5 write at E+256", tmo_q, 32'h0000_0100);
  endtask

  task automatic t_reload_R11();
    do_reset();
    wr(4'h4, 2'd2, 32'hD928_C520);
    idle(200);
    wr(4'h4, 2'd2, 32'hD928_C520);
    idle(200);
    check("R11 still open", win_open, 1);
    wr(4'h8, 2'd2, 32'h0000_0300);
    check("R11 write", tmo_q, 32'h0000_0300);
  endtask

  task automatic t_half_R4_R7();
    do_reset();
    wr(4'h4, 2'd2, 32'hD928_C520);
    wr(4'h0, 2'd2, 32'h0000_0020);
    check("R7 first write", wide_cmd, 0);
    wr(4'h4, 2'd2, 32'hD928_C520);
    check("R4 wide key ignored", win_open, 0);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd1, 32'h0000_1111);
    wr(4'h4, 2'd1, 32'h0000_D928);
    check("R4 restart value", win_open, 0);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd0, 32'h0000_0020);
    wr(4'h4, 2'd1, 32'h0000_D928);
    check("R4 restart byte", win_open, 0);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd1, 32'h0000_D928);
    check("R4 half key", win_open, 1);
    wr(4'h0, 2'd2, 32'h0000_2020);
    check("R7 bit 13 kept", ctrl_q, 32'h0000_0020);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd1, 32'h0000_D928);
    wr(4'h0, 2'd2, 32'h0000_0000);
    wr(4'h4, 2'd1, 32'h0000_C520);
    wr(4'h4, 2'd1, 32'h0000_D928);
    check("R8 half key refused", win_open, 0);
  endtask

  task automatic t_update_R8();
    do_reset();
    wr(4'h4, 2'd2, 32'hD928_C520);
    wr(4'h0, 2'd2, 32'h0000_2080);
    wr(4'h4, 2'd2, 32'hD928_C520);
    check("R8 wide key refused", win_open, 0);
    check("R9 enable kept", wdog_enabled, 1);
  endtask

  initial begin
    idle(1);
    t_reset_R1();
    t_locked_R2();
    t_wide_key_R3();
    t_window_R5();
    t_reload_R11();
    t_half_R4_R7();
    t_update_R8();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule